// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Converter-Shared Pins

This block models one 8-bit quasi-bidirectional I/O port. Each bit has an output latch that the internal bus loads with a write strobe. A bit pulls its pin low when the latch or the alternate output function is low. When both are high, the bit turns on only a weak pull-up, so the pin can also serve as an input. A read-select input picks whether the bus sees the latch contents or the pin levels.

The five low bits are shared with the inputs of an analog converter. When the converter is enabled, all five of these bits have their drivers turned off and float. The channel the converter has selected reads as 0 on the pin path, while the other four shared bits can still be read as digital inputs. The three upper bits carry alternate inputs: external interrupt 0, external interrupt 1 and the timer 0 count input. These are taken straight from the pin levels. Apart from that, the upper bits work as ordinary I/O bits. Analog behaviour is not modelled.

Top module: `qbp_port`

## Requirements
- R1: After reset every latch holds 1. A latch read (read-select 0) returns 0xFF, all pull-ups are on and no pull-down is on.
- R2: When the write strobe is high at a rising clock edge, the latch takes the write data. With the strobe low, the latch keeps its value.
- R3: Read-select 0 returns the latch contents and read-select 1 returns the pin levels.
- R4: With the converter disabled, each bit's drive value is latch AND alternate output. The pull-down is on when the drive value is 0, and the pull-up is on when it is 1. Pull-down and pull-up are never both on.
- R5: With the converter enabled, bits 0 to 4 have pull-down and pull-up both off, whatever the latch and alternate output hold.
- R6: With the converter enabled and the channel select at 0 to 4, a pin read returns 0 in the selected bit. Every other bit returns its pin level.
- R7: With the converter enabled and the channel select at 5, 6 or 7, a pin read returns the pin level on every bit, and bits 0 to 4 still float.
- R8: A latch read returns the latch contents whether or not the converter is enabled.
- R9: External interrupt 0 follows pin 5, external interrupt 1 follows pin 6 and the timer count input follows pin 7, whatever the latch holds.
- R10: Bits 5 to 7 drive as in R4 and read their pins, whether or not the converter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe for the latches |
| wr_data | input | 8 | Bus write data |
| rd_pin_sel | input | 1 | 0 reads the latches, 1 reads the pins |
| alt_drv | input | 8 | Alternate output function per bit, 1 when idle |
| pin_in | input | 8 | Pin levels |
| cnv_en | input | 1 | Converter enable |
| cnv_sel | input | 3 | Converter channel select |
| pd_en | output | 8 | Pull-down enable per pin |
| pu_en | output | 8 | Weak pull-up enable per pin |
| rd_data | output | 8 | Read data to the bus |
| ext_irq0 | output | 1 | External interrupt 0 input (pin 5) |
| ext_irq1 | output | 1 | External interrupt 1 input (pin 6) |
| tmr0_cnt | output | 1 | Timer 0 count input (pin 7) |

## Verification
The bench builds the port with its default parameters: eight bits, five converter-shared bits and a 3-bit channel select. With these values, every channel code is reached, including the three out-of-range codes 5 to 7 that must not gate any read bit. Both sides of the boundary between shared and plain bits can also be seen on the same pull-down and pull-up outputs.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  typedef enum logic {
    RD_LATCH = 1'b0,
    RD_PIN   = 1'b1
  } rd_src_e;
endpackage

// File: rtl/qbp_latch_bank.sv
module qbp_latch_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lat_q
);
  logic [W-1:0] lat_d;

  always_comb begin
    lat_d = lat_q;
    if (wr_en) lat_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '1;
    else        lat_q <= lat_d;
  end

  // R2: strobe loads, no strobe holds
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (lat_q == $past(wr_data)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lat_q));
endmodule

// File: rtl/qbp_cnv_gate.sv
module qbp_cnv_gate #(
  parameter int W    = 8,
  parameter int NANA = 5,
  parameter int CH_W = 3
) (
  input  logic            cnv_en,
  input  logic [CH_W-1:0] cnv_sel,
  output logic [W-1:0]    float_mask,
  output logic [W-1:0]    rd_kill
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < NANA) begin : g_shared
      assign float_mask[i] = cnv_en;
      assign rd_kill[i]    = cnv_en && (cnv_sel == CH_W'(i));
    end else begin : g_plain
      assign float_mask[i] = 1'b0;
      assign rd_kill[i]    = 1'b0;
    end
  end
endmodule

// File: rtl/qbp_drive.sv
module qbp_drive #(
  parameter int W = 8
) (
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] alt_drv,
  input  logic [W-1:0] float_mask,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] pu_en
);
  logic [W-1:0] drv;

  always_comb begin
    drv   = lat_q & alt_drv;
    pd_en = ~drv & ~float_mask;
    pu_en =  drv & ~float_mask;
  end
endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
  parameter int W        = 8,
  parameter int NANA     = 5,
  parameter int CH_W     = 3,
  parameter int IRQ0_BIT = 5,
  parameter int IRQ1_BIT = 6,
  parameter int TCNT_BIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  input  logic            rd_pin_sel,
  input  logic [W-1:0]    alt_drv,
  input  logic [W-1:0]    pin_in,
  input  logic            cnv_en,
  input  logic [CH_W-1:0] cnv_sel,
  output logic [W-1:0]    pd_en,
  output logic [W-1:0]    pu_en,
  output logic [W-1:0]    rd_data,
  output logic            ext_irq0,
  output logic            ext_irq1,
  output logic            tmr0_cnt
);
  import qbp_pkg::*;

  logic [1:0]   rst_sync;
  logic         rst_int_n;
  logic [W-1:0] lat_q;
  logic [W-1:0] float_mask;
  logic [W-1:0] rd_kill;
  rd_src_e      rd_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  qbp_latch_bank #(.W(W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .lat_q   (lat_q)
  );

  qbp_cnv_gate #(.W(W), .NANA(NANA), .CH_W(CH_W)) u_gate (
    .cnv_en     (cnv_en),
    .cnv_sel    (cnv_sel),
    .float_mask (float_mask),
    .rd_kill    (rd_kill)
  );

  qbp_drive #(.W(W)) u_drive (
    .lat_q      (lat_q),
    .alt_drv    (alt_drv),
    .float_mask (float_mask),
    .pd_en      (pd_en),
    .pu_en      (pu_en)
  );

  always_comb begin
    rd_src = rd_src_e'(rd_pin_sel);
    if (rd_src == RD_PIN) rd_data = pin_in & ~rd_kill;
    else                  rd_data = lat_q;
  end

  assign ext_irq0 = pin_in[IRQ0_BIT];
  assign ext_irq1 = pin_in[IRQ1_BIT];
  assign tmr0_cnt = pin_in[TCNT_BIT];

  // R4: a pin is never pulled both ways
  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pd_en & pu_en) == '0);
  // R5: shared bits float while the converter is on
  a_r5_float: assert property (@(posedge clk) disable iff (!rst_int_n)
    cnv_en |-> ((pd_en[NANA-1:0] | pu_en[NANA-1:0]) == '0));
  // R6: the selected channel reads 0 on the pin path
  a_r6_gated_read: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cnv_en && rd_pin_sel && (int'(cnv_sel) < NANA)) |-> (rd_data[cnv_sel] == 1'b0));
  // R10: upper bits always drive one way or the other
  a_r10_upper_driven: assert property (@(posedge clk) disable iff (!rst_int_n)
    &(pd_en[W-1:NANA] | pu_en[W-1:NANA]));
  // R8: latch reads do not depend on the converter
  a_r8_latch_read: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!rd_pin_sel && !wr_en && $stable(rd_pin_sel)) |=> (!rd_pin_sel -> $stable(rd_data)));
endmodule

// File: tb/test_qbp_port.sv
module test_qbp_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  typedef struct packed {
    logic [7:0] lat;
    logic [7:0] alt;
    logic [7:0] pin;
    logic       en;
    logic [2:0] sel;
    logic       rsel;
    logic [7:0] e_rd;
    logic [7:0] e_pd;
    logic [7:0] e_pu;
  } vec_t;

  // lat, alt, pin, en, sel, rsel, exp rd, exp pd, exp pu
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 8'hFF, 8'hA5, 1'b0, 3'd0, 1'b0, 8'hFF, 8'h00, 8'hFF}, // R3 latch path, R4
    '{8'hFF, 8'hFF, 8'hA5, 1'b0, 3'd0, 1'b1, 8'hA5, 8'h00, 8'hFF}, // R3 pin path
    '{8'h0F, 8'hFF, 8'h3C, 1'b0, 3'd0, 1'b1, 8'h3C, 8'hF0, 8'h0F}, // R4 latch low
    '{8'hFF, 8'hF5, 8'h00, 1'b0, 3'd0, 1'b0, 8'hFF, 8'h0A, 8'hF5}, // R4 alternate low
    '{8'h00, 8'hFF, 8'hFF, 1'b1, 3'd2, 1'b1, 8'hFB, 8'hE0, 8'h00}, // R5 R6 ch2
    '{8'hAA, 8'hFF, 8'hFF, 1'b1, 3'd0, 1'b0, 8'hAA, 8'h40, 8'hA0}, // R8 R10
    '{8'h55, 8'hFF, 8'hFF, 1'b1, 3'd4, 1'b1, 8'hEF, 8'hA0, 8'h40}, // R6 ch4 edge
    '{8'hFF, 8'hFF, 8'h1F, 1'b1, 3'd6, 1'b1, 8'h1F, 8'h00, 8'hE0}, // R7 sel 6
    '{8'hFF, 8'hFF, 8'hFF, 1'b1, 3'd5, 1'b1, 8'hFF, 8'h00, 8'hE0}  // R7 sel 5
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rd_pin_sel;
  logic [7:0] alt_drv;
  logic [7:0] pin_in;
  logic       cnv_en;
  logic [2:0] cnv_sel;
  logic [7:0] pd_en, pu_en, rd_data;
  logic       ext_irq0, ext_irq1, tmr0_cnt;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbp_port i_qbp_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_pin_sel(rd_pin_sel), .alt_drv(alt_drv), .pin_in(pin_in),
    .cnv_en(cnv_en), .cnv_sel(cnv_sel), .pd_en(pd_en), .pu_en(pu_en),
    .rd_data(rd_data), .ext_irq0(ext_irq0), .ext_irq1(ext_irq1),
    .tmr0_cnt(tmr0_cnt)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; rd_pin_sel = 1'b0;
    alt_drv = 8'hFF; pin_in = 8'h00; cnv_en = 1'b0; cnv_sel = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 latch read", rd_data, 8'hFF);
    chk("R1 pull-up",    pu_en,   8'hFF);
    chk("R1 pull-down",  pd_en,   8'h00);

    for (int v = 0; v < NV; v++) begin
      do_write(VECS[v].lat);
      alt_drv    = VECS[v].alt;
      pin_in     = VECS[v].pin;
      cnv_en     = VECS[v].en;
      cnv_sel    = VECS[v].sel;
      rd_pin_sel = VECS[v].rsel;
      #1;
      chk("R3/R6/R7/R8 rd_data", rd_data, VECS[v].e_rd);
      chk("R4/R5/R10 pd_en",     pd_en,   VECS[v].e_pd);
      chk("R4/R5/R10 pu_en",     pu_en,   VECS[v].e_pu);
    end

    // R2: load on strobe, hold without it
    cnv_en = 1'b0; alt_drv = 8'hFF; rd_pin_sel = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h5A;
    #1;
    chk("R2 before edge", rd_data, 8'hFF);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'hC3;
    #1;
    chk("R2 loaded", rd_data, 8'h5A);
    repeat (2) @(negedge clk);
    #1;
    chk("R2 held", rd_data, 8'h5A);

    // R9: alternate inputs follow pins, not latch
    do_write(8'h00);
    pin_in = 8'hA0;
    #1;
    chk("R9 alt inputs", {5'b0, tmr0_cnt, ext_irq1, ext_irq0}, 8'h05);
    pin_in = 8'h40;
    #1;
    chk("R9 alt inputs", {5'b0, tmr0_cnt, ext_irq1, ext_irq0}, 8'h02);

    // R6: every shared channel gated in turn
    do_write(8'hFF);
    pin_in = 8'hFF; cnv_en = 1'b1; rd_pin_sel = 1'b1;
    for (int c = 0; c < 5; c++) begin
      cnv_sel = 3'(c);
      #1;
      chk("R6 channel sweep", rd_data, ~(8'h01 << c));
    end

    // R1: reset mid-run restores latches
    cnv_en = 1'b0; rd_pin_sel = 1'b0;
    do_write(8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", rd_data, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule